// File: doc/BRIEF.md
# Power-Good Strap Latch Controller

This block turns a three-bit frequency strap and a test-select strap into a stable configuration word. The straps are sampled exactly once, when a combined power-good / power-down pin is first seen high for long enough. From then on the same pin is read as a live active-low power-down request. The captured code is decoded into a CPU clock frequency in MHz, and one code value is flagged as reserved.

When the test-select strap is high at the moment of capture, the block enters test mode. In test mode the frequency code follows the live strap pins instead of holding the captured value. The middle strap bit then picks the test output behaviour: tri-state or the reference clock divided by N. All pin inputs pass through a two-stage synchroniser, and only a reset re-arms the one-shot capture.

Top module: `strap_latch_ctrl`

## Requirements
- R1: While reset is held and after it is released, and until a capture occurs, freq_code_o is 3'b101, cpu_mhz_o is 100, and reserved_o, test_mode_o, test_ref_o and pwr_down_o are 0.
- R2: Once pwrgd_pd_i has been high for at least 6 clock cycles, freq_code_o holds the value fs_i had at capture, with bit 2 = FSC, bit 1 = FSB and bit 0 = FSA.
- R3: cpu_mhz_o decodes freq_code_o as follows: 000→266, 001→133, 010→200, 011→166, 100→333, 101→100, 110→400.
- R4: Code 111 drives reserved_o to 1 and cpu_mhz_o to 0. reserved_o is 0 for every other code.
- R5: A high pulse on pwrgd_pd_i that lasts one clock cycle and has low on both sides does not capture the straps.
- R6: Outside test mode, once a capture has occurred, later changes on fs_i, test_sel_i and later high periods of pwrgd_pd_i do not change freq_code_o.
- R7: After capture, pwr_down_o is 1 within 4 cycles of pwrgd_pd_i going low and returns to 0 within 4 cycles of it going high. Before capture, pwr_down_o stays 0 whatever the pin does.
- R8: test_mode_o becomes 1 when test_sel_i is high at capture. It then stays at its captured value until reset, regardless of test_sel_i.
- R9: In test mode, freq_code_o follows fs_i within 4 cycles of a change.
- R10: test_ref_o is 1 (reference divided by N) only in test mode with fs_i bit 1 high. It is 0 (tri-state) otherwise.
- R11: Asserting rst_ni low re-arms the capture, so a new power-good rise latches new strap values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset, re-arms capture |
| fs_i | input | 3 | Frequency-select straps {FSC,FSB,FSA} |
| test_sel_i | input | 1 | Test-select strap level |
| pwrgd_pd_i | input | 1 | Power-good strobe, then active-low power-down |
| freq_code_o | output | 3 | Latched (or, in test mode, live) frequency code |
| cpu_mhz_o | output | 9 | Decoded CPU frequency in MHz, 0 if reserved |
| reserved_o | output | 1 | Code 111 flag |
| test_mode_o | output | 1 | Test mode active |
| test_ref_o | output | 1 | Test output: 1 = reference/N, 0 = tri-state |
| pwr_down_o | output | 1 | Power-down request |

## Verification
The hardest state to reach is a second, genuinely qualified high on the strobe after capture, with different strap values presented. To get there, the stimulus captures once, drops the pin to assert power-down, changes fs_i and test_sel_i, and then raises the pin for many cycles, which would re-capture if the one-shot failed. Glitch rejection is exercised with a single-cycle pulse driven on the falling clock edge, so that the synchronised strobe is high for exactly one sample. Test mode is reached through a separate reset and capture with test_sel_i high, after which the straps are toggled live.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int FS_W  = 3;
  localparam int MHZ_W = 9;

  typedef logic [FS_W-1:0]  fs_code_t;
  typedef logic [MHZ_W-1:0] mhz_t;

  typedef enum logic {
    TST_TRISTATE = 1'b0,
    TST_REFDIV   = 1'b1
  } test_out_e;

  localparam fs_code_t FS_RESERVED = 3'b111;
  localparam int       FSB_BIT     = 1;
endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s > 0) ? s-1 : 0];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pgood_qualifier.sv
module pgood_qualifier #(
  parameter int QUAL = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pg_s_i,
  output logic qual_o
);
  localparam int CW = (QUAL > 1) ? $clog2(QUAL) : 1;
  localparam logic [CW-1:0] LAST = CW'(QUAL - 1);

  logic [CW-1:0] hi_cnt_q;

  // counts consecutive high samples already seen, saturating at QUAL-1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          hi_cnt_q <= '0;
    else if (!pg_s_i)     hi_cnt_q <= '0;
    else if (hi_cnt_q != LAST) hi_cnt_q <= hi_cnt_q + 1'b1;
  end

  assign qual_o = pg_s_i && (hi_cnt_q == LAST);
endmodule

// File: rtl/strap_capture.sv
module strap_capture
  import strap_pkg::*;
#(
  parameter fs_code_t DEF_CODE = 3'b101
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  fs_code_t fs_s_i,
  input  logic     tsel_s_i,
  input  logic     pg_s_i,
  input  logic     qual_i,
  output fs_code_t code_o,
  output logic     captured_o,
  output logic     test_mode_o,
  output logic     test_ref_o,
  output logic     pwr_down_o
);
  fs_code_t code_q;
  logic     cap_q, tmode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q  <= DEF_CODE;
      cap_q   <= 1'b0;
      tmode_q <= 1'b0;
    end else if (!cap_q) begin
      if (qual_i) begin
        cap_q   <= 1'b1;
        code_q  <= fs_s_i;
        tmode_q <= tsel_s_i;
      end
    end else if (tmode_q) begin
      code_q <= fs_s_i;   // live straps in test mode
    end
  end

  test_out_e tout;
  assign tout = (tmode_q && code_q[FSB_BIT]) ? TST_REFDIV : TST_TRISTATE;

  assign code_o      = code_q;
  assign captured_o  = cap_q;
  assign test_mode_o = tmode_q;
  assign test_ref_o  = (tout == TST_REFDIV);
  assign pwr_down_o  = cap_q && !pg_s_i;
endmodule

// File: rtl/freq_decoder.sv
module freq_decoder
  import strap_pkg::*;
(
  input  fs_code_t code_i,
  output mhz_t     mhz_o,
  output logic     reserved_o
);
  always_comb begin
    reserved_o = 1'b0;
    unique case (code_i)
      3'b000:  mhz_o = 9'd266;
      3'b001:  mhz_o = 9'd133;
      3'b010:  mhz_o = 9'd200;
      3'b011:  mhz_o = 9'd166;
      3'b100:  mhz_o = 9'd333;
      3'b101:  mhz_o = 9'd100;
      3'b110:  mhz_o = 9'd400;
      default: begin
        mhz_o      = '0;
        reserved_o = (code_i == FS_RESERVED);
      end
    endcase
  end
endmodule

// File: rtl/strap_latch_ctrl.sv
module strap_latch_ctrl
  import strap_pkg::*;
#(
  parameter int       SYNC_STAGES = 2,
  parameter int       QUAL        = 2,
  parameter fs_code_t DEF_CODE    = 3'b101
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] fs_i,
  input  logic       test_sel_i,
  input  logic       pwrgd_pd_i,
  output logic [2:0] freq_code_o,
  output logic [8:0] cpu_mhz_o,
  output logic       reserved_o,
  output logic       test_mode_o,
  output logic       test_ref_o,
  output logic       pwr_down_o
);
  localparam int PIN_W = FS_W + 2;

  logic [PIN_W-1:0] pins_s;
  fs_code_t         fs_s, code;
  logic             tsel_s, pg_s, qual, captured;

  strap_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({pwrgd_pd_i, test_sel_i, fs_i}),
    .q_o    (pins_s)
  );

  assign fs_s   = pins_s[FS_W-1:0];
  assign tsel_s = pins_s[FS_W];
  assign pg_s   = pins_s[FS_W+1];

  pgood_qualifier #(.QUAL(QUAL)) u_qual (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pg_s_i (pg_s),
    .qual_o (qual)
  );

  strap_capture #(.DEF_CODE(DEF_CODE)) u_cap (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fs_s_i      (fs_s),
    .tsel_s_i    (tsel_s),
    .pg_s_i      (pg_s),
    .qual_i      (qual),
    .code_o      (code),
    .captured_o  (captured),
    .test_mode_o (test_mode_o),
    .test_ref_o  (test_ref_o),
    .pwr_down_o  (pwr_down_o)
  );

  freq_decoder u_dec (
    .code_i     (code),
    .mhz_o      (cpu_mhz_o),
    .reserved_o (reserved_o)
  );

  assign freq_code_o = code;
endmodule

// File: rtl/strap_latch_ctrl_chk.sv
module strap_latch_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       captured,
  input logic       pg_s,
  input logic [2:0] freq_code_o,
  input logic [8:0] cpu_mhz_o,
  input logic       reserved_o,
  input logic       test_mode_o,
  input logic       test_ref_o,
  input logic       pwr_down_o
);
  // R7
  pd_before_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !captured |-> !pwr_down_o);

  // R6
  code_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (captured && !test_mode_o) |=> $stable(freq_code_o));

  // R4
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reserved_o |-> (cpu_mhz_o == 9'd0));

  // R8
  test_mode_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_mode_o |=> test_mode_o);

  // R10
  test_ref_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !test_mode_o |-> !test_ref_o);

  // R5
  capture_qualified_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(captured) |-> $past(pg_s));

  // R1
  no_mode_precap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !captured |-> !test_mode_o);
endmodule

bind strap_latch_ctrl strap_latch_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .captured    (captured),
  .pg_s        (pg_s),
  .freq_code_o (freq_code_o),
  .cpu_mhz_o   (cpu_mhz_o),
  .reserved_o  (reserved_o),
  .test_mode_o (test_mode_o),
  .test_ref_o  (test_ref_o),
  .pwr_down_o  (pwr_down_o)
);

// File: tb/strap_latch_ctrl_tb_top.sv
module strap_latch_ctrl_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] fs_i = '0;
  logic       test_sel_i = 1'b0;
  logic       pwrgd_pd_i = 1'b0;
  logic [2:0] freq_code_o;
  logic [8:0] cpu_mhz_o;
  logic       reserved_o, test_mode_o, test_ref_o, pwr_down_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  strap_latch_ctrl dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fs_i        (fs_i),
    .test_sel_i  (test_sel_i),
    .pwrgd_pd_i  (pwrgd_pd_i),
    .freq_code_o (freq_code_o),
    .cpu_mhz_o   (cpu_mhz_o),
    .reserved_o  (reserved_o),
    .test_mode_o (test_mode_o),
    .test_ref_o  (test_ref_o),
    .pwr_down_o  (pwr_down_o)
  );

  // {fs, mhz, reserved}
  localparam logic [12:0] VEC [8] = '{
    {3'b000, 9'd266, 1'b0}, {3'b001, 9'd133, 1'b0},
    {3'b010, 9'd200, 1'b0}, {3'b011, 9'd166, 1'b0},
    {3'b100, 9'd333, 1'b0}, {3'b101, 9'd100, 1'b0},
    {3'b110, 9'd400, 1'b0}, {3'b111, 9'd0,   1'b1}
  };

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    pwrgd_pd_i = 1'b0;
    cyc(3);
    rst_ni = 1'b1;
    cyc(2);
  endtask

  task automatic chk_default(input string req);
    chk(req, freq_code_o, 3'b101);
    chk(req, cpu_mhz_o, 100);
    chk(req, reserved_o, 0);
    chk(req, test_mode_o, 0);
    chk(req, test_ref_o, 0);
    chk(req, pwr_down_o, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: state while held in reset and after release
    cyc(2);
    chk_default("R1 in reset");
    do_reset();
    chk_default("R1 after reset");

    // table: R2 capture, R3 decode, R4 reserved, R7 power-down
    for (int i = 0; i < 8; i++) begin
      do_reset();
      fs_i = VEC[i][12:10];
      test_sel_i = 1'b0;
      cyc(3);
      pwrgd_pd_i = 1'b1;
      cyc(6);
      chk("R2 capture", freq_code_o, VEC[i][12:10]);
      chk("R3 decode", cpu_mhz_o, VEC[i][9:1]);
      chk("R4 reserved", reserved_o, VEC[i][0]);
      chk("R7 pd high", pwr_down_o, 0);
      pwrgd_pd_i = 1'b0;
      cyc(4);
      chk("R7 pd low", pwr_down_o, 1);
      pwrgd_pd_i = 1'b1;
      cyc(4);
      chk("R7 pd release", pwr_down_o, 0);
    end

    // R5 glitch rejection, R7 no power-down before capture
    do_reset();
    fs_i = 3'b010;
    cyc(3);
    pwrgd_pd_i = 1'b1;
    cyc(1);
    pwrgd_pd_i = 1'b0;
    cyc(6);
    chk("R5 glitch code", freq_code_o, 3'b101);
    chk("R7 no pd precap", pwr_down_o, 0);

    // R6 one-shot: straps and second strobe ignored
    fs_i = 3'b100;
    cyc(3);
    pwrgd_pd_i = 1'b1;
    cyc(6);
    chk("R6 first capture", freq_code_o, 3'b100);
    fs_i = 3'b000;
    test_sel_i = 1'b1;
    cyc(5);
    chk("R6 fs ignored", freq_code_o, 3'b100);
    pwrgd_pd_i = 1'b0;
    cyc(5);
    pwrgd_pd_i = 1'b1;
    cyc(10);
    chk("R6 recapture ignored", freq_code_o, 3'b100);
    chk("R6 mhz held", cpu_mhz_o, 333);
    chk("R8 tsel ignored", test_mode_o, 0);

    // R11: reset re-arms
    test_sel_i = 1'b0;
    do_reset();
    chk("R11 default after reset", freq_code_o, 3'b101);
    fs_i = 3'b110;
    cyc(3);
    pwrgd_pd_i = 1'b1;
    cyc(6);
    chk("R11 new capture", freq_code_o, 3'b110);

    // R8 test mode entry, R9 live tracking, R10 test output select
    do_reset();
    fs_i = 3'b000;
    test_sel_i = 1'b1;
    cyc(3);
    pwrgd_pd_i = 1'b1;
    cyc(6);
    chk("R8 test entry", test_mode_o, 1);
    chk("R10 tristate", test_ref_o, 0);
    test_sel_i = 1'b0;
    fs_i = 3'b011;
    cyc(4);
    chk("R9 live code", freq_code_o, 3'b011);
    chk("R10 refdiv", test_ref_o, 1);
    chk("R8 test sticky", test_mode_o, 1);
    fs_i = 3'b101;
    cyc(4);
    chk("R9 live code 2", freq_code_o, 3'b101);
    chk("R10 tristate 2", test_ref_o, 0);
    pwrgd_pd_i = 1'b0;
    cyc(4);
    chk("R7 pd in test", pwr_down_o, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule